// File: doc/BRIEF.md
# Multichannel DAC Command Register Bank

This block is the digital front end of a bank of four or eight voltage-output DAC channels. It takes 16-bit command words, each presented in parallel for one cycle with a valid strobe. A two-bit mode field in each word selects one of three targets. The first is a global configuration register for the whole bank. The second is a per-channel control register. The third is a pair of per-channel data registers: a 10-bit main code and an 8-bit offset (sub) code. The block keeps every channel's state and drives the codes and control levels that the analog channels consume.

The data registers are double buffered. Writes land in a holding register. A falling edge on the active-low load input copies every channel's holding registers into its active registers in the same cycle. An active-low hardware clear zeroes the holding and active registers of both paths on every channel. A software clear, either bank-wide or for one channel, zeroes only the main path. All inputs are sampled on the rising clock edge, and every output is registered, so any effect is visible after the edge that samples its cause.

Top module: `dac_cmd_bank`

## Requirements
- R1: Bit 14 is mode bit A and bit 13 is mode bit B. B=0 with A=0 targets the global configuration register. B=0 with A=1 targets a channel control register. B=1 targets a data register, whatever the value of A. Words with the valid strobe low have no effect.
- R2: A global configuration write takes bit 6 as the coding select (1 = offset binary, 0 = twos complement), bit 5 as the power bit (0 = low power, 1 = normal) and bit 4 as bank standby. Address bits and bit 15 are ignored. The new values appear on the outputs after the sampling edge.
- R3: A global configuration word with bit 7 or bit 2 set is discarded as a whole. It changes no configuration bit and performs no clear.
- R4: A channel control write updates only the addressed channel. It takes bits 9:8 as the reference-mux select and bit 4 as channel standby. The address is bits 12:10 with eight channels. With four channels it is bits 11:10, and bit 12 is ignored.
- R5: A data write with bit 15 = 0 stores bits 9:0 in the addressed channel's main holding register. With bit 15 = 1 it stores bits 9:2 in the sub holding register, and bits 1:0 are ignored. Active codes do not change on a data write.
- R6: In the cycle where the load input is first sampled low after being high, every channel copies both holding registers into its active registers. Holding the load input low gives no further copies, and active registers otherwise keep their value.
- R7: While the hardware clear input is sampled low, the main and sub holding and active registers of every channel become zero. This takes priority over writes and loads. Control registers are not affected.
- R8: A software clear zeroes the main holding and main active registers and leaves the sub registers untouched. Bit 3 of a global configuration write clears all channels. Bit 3 of a channel control write clears the addressed channel. Clear bits are not retained, so later writes and loads behave normally.
- R9: Each channel's standby output is high when that channel's standby bit or the bank standby bit is set.
- R10: Low-power mode changes no register. Active codes and holding contents are kept and remain valid when normal power is restored.
- R11: After reset, all codes, mux selects, standby bits, the coding select and the power bit are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe qualifying cmd_word |
| cmd_word | input | 16 | Command word |
| load_n | input | 1 | Active-low load; falling edge transfers holding to active |
| hwclr_n | input | 1 | Active-low hardware clear of all data registers |
| act_main | output | NCH*10 | Active main code per channel, channel 0 in the low bits |
| act_sub | output | NCH*8 | Active sub (offset) code per channel |
| ref_sel | output | NCH*2 | Reference-mux select per channel |
| chan_stby | output | NCH | Effective standby per channel |
| coding_ob | output | 1 | 1 = offset binary, 0 = twos complement |
| pwr_on | output | 1 | 1 = normal operation, 0 = low power |
| bank_stby | output | 1 | Bank-wide standby |

## Verification
The in-line assertions check on every cycle that the active registers hold between loads and that a load copies the holding contents of the previous cycle. They also check that both clears leave the right registers at zero while the sub path survives a software clear, that at most one channel accepts a control write, and that a global word with reserved bits set leaves the configuration unchanged. Other behaviours can only be shown by the bench's scenarios. These include the field positions of every word type, the mode-A don't-care on data writes, the address aliasing in the four-channel build, the merge of bank and channel standby, and register retention across low-power mode. The bench shows them with sweeps over all eight channels, compared against an arithmetic model.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
   localparam int WORD_W  = 16;
   localparam int MAIN_W  = 10;
   localparam int SUB_W   = 8;
   localparam int MUX_W   = 2;

   localparam int B_TGT   = 15;
   localparam int B_MDA   = 14;
   localparam int B_MDB   = 13;
   localparam int B_ADDR  = 10;
   localparam int B_MUX   = 8;
   localparam int B_RSV_H = 7;
   localparam int B_COD   = 6;
   localparam int B_PWR   = 5;
   localparam int B_STBY  = 4;
   localparam int B_CLR   = 3;
   localparam int B_RSV_L = 2;
   localparam int B_SUB   = 2;

   typedef struct packed {
      logic coding_ob;
      logic pwr_on;
      logic bank_stby;
   } bank_cfg_t;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
   import dac_cmd_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int ADDR_W = 3
) (
   input  logic              valid,
   input  logic [WORD_W-1:0] word,
   output logic              cfg_wr,
   output logic              cfg_clr,
   output bank_cfg_t         cfg_nxt,
   output logic [NCH-1:0]    ctl_sel,
   output logic [NCH-1:0]    main_sel,
   output logic [NCH-1:0]    sub_sel,
   output logic [MUX_W-1:0]  ctl_mux,
   output logic              ctl_stby,
   output logic              ctl_clr,
   output logic [MAIN_W-1:0] main_din,
   output logic [SUB_W-1:0]  sub_din
);
   logic              is_cfg, is_ctl, is_dat, rsv_bad;
   logic [ADDR_W-1:0] addr;

   assign rsv_bad = word[B_RSV_H] | word[B_RSV_L];
   assign is_cfg  = valid & ~word[B_MDB] & ~word[B_MDA];
   assign is_ctl  = valid & ~word[B_MDB] &  word[B_MDA];
   assign is_dat  = valid &  word[B_MDB];
   assign addr    = word[B_ADDR +: ADDR_W];

   generate
      if (ADDR_W < 3) begin : g_narrow
         logic unused_hi_addr;
         assign unused_hi_addr = ^word[B_ADDR+2:B_ADDR+ADDR_W];
      end
   endgenerate

   assign cfg_wr            = is_cfg & ~rsv_bad;
   assign cfg_clr           = cfg_wr & word[B_CLR];
   assign cfg_nxt.coding_ob = word[B_COD];
   assign cfg_nxt.pwr_on    = word[B_PWR];
   assign cfg_nxt.bank_stby = word[B_STBY];

   assign ctl_mux  = word[B_MUX +: MUX_W];
   assign ctl_stby = word[B_STBY];
   assign ctl_clr  = word[B_CLR];
   assign main_din = word[MAIN_W-1:0];
   assign sub_din  = word[B_SUB +: SUB_W];

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_sel
         logic hit;
         assign hit         = (addr == ADDR_W'(i));
         assign ctl_sel[i]  = is_ctl & hit;
         assign main_sel[i] = is_dat & hit & ~word[B_TGT];
         assign sub_sel[i]  = is_dat & hit &  word[B_TGT];
      end
   endgenerate
endmodule

// File: rtl/dac_bank_cfg.sv
module dac_bank_cfg
   import dac_cmd_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cfg_wr,
   input  bank_cfg_t cfg_nxt,
   output bank_cfg_t cfg_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_wr) cfg_q <= cfg_nxt;
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(cfg_q)); // R3
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
   import dac_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hwclr,
   input  logic              ld_pulse,
   input  logic              bank_clr,
   input  logic              ctl_wr,
   input  logic [MUX_W-1:0]  ctl_mux,
   input  logic              ctl_stby,
   input  logic              ctl_clr,
   input  logic              main_wr,
   input  logic              sub_wr,
   input  logic [MAIN_W-1:0] main_din,
   input  logic [SUB_W-1:0]  sub_din,
   output logic [MAIN_W-1:0] act_main,
   output logic [SUB_W-1:0]  act_sub,
   output logic [MUX_W-1:0]  mux_q,
   output logic              stby_q
);
   logic [MAIN_W-1:0] main_q;
   logic [SUB_W-1:0]  sub_q;
   logic              swclr;

   assign swclr = bank_clr | (ctl_wr & ctl_clr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mux_q  <= '0;
         stby_q <= 1'b0;
      end else if (ctl_wr) begin
         mux_q  <= ctl_mux;
         stby_q <= ctl_stby;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || hwclr) begin
         main_q   <= '0;
         act_main <= '0;
      end else if (swclr) begin
         main_q   <= '0;
         act_main <= '0;
      end else begin
         if (main_wr)  main_q   <= main_din;
         if (ld_pulse) act_main <= main_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || hwclr) begin
         sub_q   <= '0;
         act_sub <= '0;
      end else begin
         if (sub_wr)   sub_q   <= sub_din;
         if (ld_pulse) act_sub <= sub_q;
      end
   end

   AST_HWCLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      hwclr |=> (main_q == '0 && act_main == '0 && sub_q == '0 && act_sub == '0)); // R7
   AST_SWCLR_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!hwclr && swclr) |=> (main_q == '0 && act_main == '0)); // R8
   AST_SWCLR_SUB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!hwclr && swclr && !ld_pulse && !sub_wr) |=> ($stable(act_sub) && $stable(sub_q))); // R8
   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (!hwclr && !swclr && ld_pulse) |=> (act_main == $past(main_q) && act_sub == $past(sub_q))); // R6
   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hwclr && !swclr && !ld_pulse) |=> ($stable(act_main) && $stable(act_sub))); // R6
endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
   import dac_cmd_pkg::*;
#(
   parameter int NCH = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [WORD_W-1:0]     cmd_word,
   input  logic                  load_n,
   input  logic                  hwclr_n,
   output logic [NCH*MAIN_W-1:0] act_main,
   output logic [NCH*SUB_W-1:0]  act_sub,
   output logic [NCH*MUX_W-1:0]  ref_sel,
   output logic [NCH-1:0]        chan_stby,
   output logic                  coding_ob,
   output logic                  pwr_on,
   output logic                  bank_stby
);
   localparam int ADDR_W = (NCH > 4) ? 3 : 2;

   generate
      if (NCH != 4 && NCH != 8) begin : g_bad_nch
         $error("dac_cmd_bank: NCH must be 4 or 8");
      end
   endgenerate

   logic              cfg_wr, cfg_clr, ctl_stby, ctl_clr;
   bank_cfg_t         cfg_nxt, cfg_q;
   logic [NCH-1:0]    ctl_sel, main_sel, sub_sel, stby_vec;
   logic [MUX_W-1:0]  ctl_mux;
   logic [MAIN_W-1:0] main_din;
   logic [SUB_W-1:0]  sub_din;
   logic              ld_prev, ld_pulse, hwclr;

   always_ff @(posedge clk) begin
      if (!rst_n) ld_prev <= 1'b1;
      else        ld_prev <= load_n;
   end
   assign ld_pulse = ld_prev & ~load_n;
   assign hwclr    = ~hwclr_n;

   dac_cmd_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
      .valid(cmd_valid), .word(cmd_word),
      .cfg_wr(cfg_wr), .cfg_clr(cfg_clr), .cfg_nxt(cfg_nxt),
      .ctl_sel(ctl_sel), .main_sel(main_sel), .sub_sel(sub_sel),
      .ctl_mux(ctl_mux), .ctl_stby(ctl_stby), .ctl_clr(ctl_clr),
      .main_din(main_din), .sub_din(sub_din)
   );

   dac_bank_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_nxt(cfg_nxt), .cfg_q(cfg_q)
   );

   assign coding_ob = cfg_q.coding_ob;
   assign pwr_on    = cfg_q.pwr_on;
   assign bank_stby = cfg_q.bank_stby;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         dac_chan_regs u_ch (
            .clk(clk), .rst_n(rst_n), .hwclr(hwclr), .ld_pulse(ld_pulse),
            .bank_clr(cfg_clr), .ctl_wr(ctl_sel[i]), .ctl_mux(ctl_mux),
            .ctl_stby(ctl_stby), .ctl_clr(ctl_clr),
            .main_wr(main_sel[i]), .sub_wr(sub_sel[i]),
            .main_din(main_din), .sub_din(sub_din),
            .act_main(act_main[i*MAIN_W +: MAIN_W]),
            .act_sub(act_sub[i*SUB_W +: SUB_W]),
            .mux_q(ref_sel[i*MUX_W +: MUX_W]),
            .stby_q(stby_vec[i])
         );
         assign chan_stby[i] = stby_vec[i] | cfg_q.bank_stby;
      end
   endgenerate

   AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctl_sel) && $onehot0(main_sel | sub_sel)); // R4
   AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_word[B_MDB] && !cmd_word[B_MDA] && (cmd_word[B_RSV_H] || cmd_word[B_RSV_L]))
      |=> $stable(cfg_q)); // R3
   AST_NO_STROBE_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(cfg_q)); // R1
endmodule

// File: tb/dac_cmd_bank_test.sv
`timescale 1ns/1ps
module dac_cmd_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        load_n = 1'b1;
   logic        hwclr_n = 1'b1;
   logic [79:0] act_main;
   logic [63:0] act_sub;
   logic [15:0] ref_sel;
   logic [7:0]  chan_stby;
   logic        coding_ob, pwr_on, bank_stby;
   logic [39:0] a4_main;
   logic [31:0] a4_sub;
   logic [7:0]  r4_sel;
   logic [3:0]  s4_stby;
   logic        c4, p4, b4;

   int checks = 0;
   int errors = 0;

   logic [9:0] m_main [8];
   logic [9:0] m_amain [8];
   logic [7:0] m_sub [8];
   logic [7:0] m_asub [8];
   logic [1:0] m_mux [8];
   logic       m_stby [8];
   logic       m_cod, m_pwr, m_bst;

   always #2.5 clk = ~clk;

   dac_cmd_bank #(.NCH(8)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .load_n(load_n), .hwclr_n(hwclr_n), .act_main(act_main), .act_sub(act_sub),
      .ref_sel(ref_sel), .chan_stby(chan_stby), .coding_ob(coding_ob),
      .pwr_on(pwr_on), .bank_stby(bank_stby)
   );

   dac_cmd_bank #(.NCH(4)) u4 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .load_n(load_n), .hwclr_n(hwclr_n), .act_main(a4_main), .act_sub(a4_sub),
      .ref_sel(r4_sel), .chan_stby(s4_stby), .coding_ob(c4),
      .pwr_on(p4), .bank_stby(b4)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int i = 0; i < 8; i++) begin
         chk(req, $sformatf("act_main[%0d]", i), int'(act_main[i*10 +: 10]), int'(m_amain[i]));
         chk(req, $sformatf("act_sub[%0d]", i),  int'(act_sub[i*8 +: 8]),   int'(m_asub[i]));
         chk(req, $sformatf("ref_sel[%0d]", i),  int'(ref_sel[i*2 +: 2]),   int'(m_mux[i]));
         chk(req, $sformatf("chan_stby[%0d]", i), int'(chan_stby[i]), int'(m_stby[i] | m_bst));
      end
      chk(req, "coding_ob", int'(coding_ob), int'(m_cod));
      chk(req, "pwr_on",    int'(pwr_on),    int'(m_pwr));
      chk(req, "bank_stby", int'(bank_stby), int'(m_bst));
   endtask

   function automatic logic [15:0] w_cfg(input bit cod, input bit pwr, input bit st, input bit clr);
      return {1'b1, 2'b00, 3'b101, 2'b11, 1'b0, cod, pwr, st, clr, 1'b0, 2'b11};
   endfunction
   function automatic logic [15:0] w_ctl(input int a, input int mux, input bit st, input bit clr);
      return {1'b0, 2'b10, 3'(a), 2'(mux), 3'b000, st, clr, 3'b000};
   endfunction
   function automatic logic [15:0] w_main(input int a, input int v, input bit mda);
      return {1'b0, mda, 1'b1, 3'(a), 10'(v)};
   endfunction
   function automatic logic [15:0] w_sub(input int a, input int v, input bit mda);
      return {1'b1, mda, 1'b1, 3'(a), 8'(v), 2'b11};
   endfunction

   task automatic send(input logic [15:0] w);
      int a;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_word  = w;
      @(negedge clk);
      cmd_valid = 1'b0;
      a = int'(w[12:10]);
      if (w[13]) begin
         if (w[15]) m_sub[a] = w[9:2];
         else       m_main[a] = w[9:0];
      end else if (w[14]) begin
         m_mux[a]  = w[9:8];
         m_stby[a] = w[4];
         if (w[3]) begin m_main[a] = '0; m_amain[a] = '0; end
      end else if (!w[7] && !w[2]) begin
         m_cod = w[6]; m_pwr = w[5]; m_bst = w[4];
         if (w[3]) for (int i = 0; i < 8; i++) begin m_main[i] = '0; m_amain[i] = '0; end
      end
   endtask

   task automatic load_pulse();
      @(negedge clk); load_n = 1'b0;
      @(negedge clk); load_n = 1'b1;
      for (int i = 0; i < 8; i++) begin m_amain[i] = m_main[i]; m_asub[i] = m_sub[i]; end
   endtask

   task automatic hw_clear();
      @(negedge clk); hwclr_n = 1'b0;
      @(negedge clk); hwclr_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
         m_main[i] = '0; m_amain[i] = '0; m_sub[i] = '0; m_asub[i] = '0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_main[i] = '0; m_amain[i] = '0; m_sub[i] = '0; m_asub[i] = '0;
         m_mux[i] = '0; m_stby[i] = 1'b0;
      end
      m_cod = 0; m_pwr = 0; m_bst = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R11");

      // R2: global write with address bits and bit 15 set
      send(w_cfg(1, 1, 0, 0));
      check_all("R2");
      // R3: reserved bit 7, then bit 2
      send(w_cfg(0, 0, 1, 1) | 16'h0080);
      check_all("R3");
      send(w_cfg(0, 0, 1, 1) | 16'h0004);
      check_all("R3");
      // R1: no strobe, no effect
      @(negedge clk); cmd_word = w_cfg(0, 0, 1, 0);
      @(negedge clk); @(negedge clk);
      check_all("R1");

      // R4: channel control sweep
      for (int a = 0; a < 8; a++) begin
         send(w_ctl(a, (a * 3) % 4, a[0], 0));
         check_all("R4");
      end

      // R5 / R1: data sweep, mode bit A varied, actives held
      for (int k = 0; k < 3; k++) begin
         for (int a = 0; a < 8; a++) begin
            send(w_main(a, (a * 131 + k * 257 + 5) % 1024, a[1] ^ k[0]));
            send(w_sub(a, (a * 29 + k * 83 + 1) % 256, a[0]));
         end
         check_all("R5");
         load_pulse();
         check_all("R6");
      end

      // R6: load held low gives one copy only
      @(negedge clk); load_n = 1'b0;
      for (int i = 0; i < 8; i++) begin m_amain[i] = m_main[i]; m_asub[i] = m_sub[i]; end
      send(w_main(2, 777, 0));
      send(w_sub(5, 201, 1));
      repeat (3) @(negedge clk);
      check_all("R6");
      @(negedge clk); load_n = 1'b1;
      @(negedge clk);
      check_all("R6");
      load_pulse();
      check_all("R6");

      // R9: bank standby merges into every channel
      send(w_cfg(0, 1, 1, 0));
      check_all("R9");
      send(w_cfg(0, 1, 0, 0));
      check_all("R9");

      // R10: low power keeps all registers
      send(w_cfg(1, 0, 0, 0));
      check_all("R10");
      repeat (4) @(negedge clk);
      send(w_cfg(1, 1, 0, 0));
      check_all("R10");
      load_pulse();
      check_all("R10");

      // R8: channel software clear, sub untouched
      send(w_ctl(3, 1, 0, 1));
      check_all("R8");
      load_pulse();
      check_all("R8");
      send(w_main(3, 513, 0));
      load_pulse();
      check_all("R8");
      chk("R8", "act_main[3] after clear", int'(act_main[30 +: 10]), 513);
      // R8: bank software clear
      send(w_cfg(1, 1, 0, 1));
      check_all("R8");
      send(w_main(6, 99, 1));
      load_pulse();
      check_all("R8");

      // R7: hardware clear, then combined with a load edge
      for (int a = 0; a < 8; a++) send(w_main(a, a * 100 + 7, 0));
      load_pulse();
      hw_clear();
      check_all("R7");
      for (int a = 0; a < 8; a++) send(w_sub(a, a * 20 + 3, 0));
      @(negedge clk); load_n = 1'b0; hwclr_n = 1'b0;
      @(negedge clk); load_n = 1'b1; hwclr_n = 1'b1;
      for (int i = 0; i < 8; i++) begin m_sub[i] = '0; m_asub[i] = '0; end
      check_all("R7");

      // R4: four-channel build ignores bit 12 (address 6 -> channel 2)
      send(w_ctl(6, 3, 1, 0));
      check_all("R4");
      chk("R4", "u4 ref_sel[2]", int'(r4_sel[4 +: 2]), 3);
      chk("R4", "u4 chan_stby[2]", int'(s4_stby[2]), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule